// File: doc/BRIEF.md
# Line-Fill Instruction Boundary Predecoder

This block marks where every instruction begins inside one 64-byte instruction cache line while that line is being filled. Instructions are a mix of 16-bit and 32-bit encodings. Instructions may not cross a line edge, so the first instruction of every line begins at byte 0. That lets the scan start at the top of the line without a fetch entry point. The result can then be stored next to the line and reused by every later fetch.

The line is treated as a row of 16-bit parcels. Each parcel's length class comes from its two lowest bits. A start mask is found by a prefix scan along the row, because whether a parcel starts an instruction depends on every instruction before it. A per-parcel length bit and a fault flag are registered with the start mask. The fault flag marks a 32-bit instruction that would run past the end of the line. A separate combinational port takes a branch target's parcel index and a stored start mask, and reports a target that lands inside an instruction.

The scan has two structural variants, chosen by parameter: a plain ripple chain, or a split chain whose upper half is evaluated for both possible entry states and then selected.

Top module: `lbp_predecoder`

## Requirements
- R1: While reset is asserted and after its release, before any fill, the start mask, length mask and crossing-fault flag are all zero.
- R2: A fill pulse (fill_valid_i high for one clock) is captured on that clock edge, and the three results are visible after that edge. Without a pulse, all three results hold their values whatever fill_line_i does.
- R3: Parcel 0 is always marked as a start after any fill.
- R4: Parcel i is bits [16i+15:16i] of fill_line_i. A starting parcel whose bits [1:0] equal 2'b11 begins a 32-bit instruction. Any other value of those bits begins a 16-bit instruction, and the next parcel is then also a start.
- R5: The parcel after the first parcel of a 32-bit instruction is never a start. Its own low bits are ignored, and the parcel after it is a start.
- R6: A length-mask bit is 1 exactly where that parcel is a start of a 32-bit instruction, and 0 elsewhere.
- R7: The crossing-fault flag is 1 exactly when the last parcel (31) is a start with bits [1:0] equal to 2'b11. That parcel is still marked in both masks.
- R8: tgt_misaligned_o is 1 when bit tgt_idx_i of tgt_mask_i is 0, and 0 when it is 1. It is combinational, with no clock delay.
- R9: Both scan variants (SCAN_SPLIT 0 and 1) produce identical results for every line.

Ports follow the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid_i | input | 1 | One-cycle fill pulse |
| fill_line_i | input | 512 | Line being filled, parcel 0 in the low bits |
| start_mask_o | output | 32 | 1 where a parcel begins an instruction |
| len_mask_o | output | 32 | 1 where a parcel begins a 32-bit instruction |
| cross_fault_o | output | 1 | A 32-bit instruction starts in the last parcel |
| tgt_idx_i | input | 5 | Branch target parcel index |
| tgt_mask_i | input | 32 | Stored start mask used for the lookup |
| tgt_misaligned_o | output | 1 | Target is not an instruction start |

## Verification
A fill capture and a target lookup can fall in the same cycle. The lookup is fed from the registered start mask, so during a cycle with a fill pulse it must still answer against the previous line's mask. After the edge it must answer against the new mask. The bench provokes this by driving a fill pulse and a lookup together, with the lookup mask taken from the outputs. It judges the lookup against the old reference mask before the edge and against the new reference mask after it. Random lines, all-16-bit lines, all-32-bit lines and a line that ends in a crossing instruction are all compared against a bench reference scan, and against a second instance that uses the other scan variant.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
   localparam int PARCEL_W = 16;
   localparam int CLASS_BITS = 2;
   localparam logic [CLASS_BITS-1:0] WIDE_CODE = 2'b11;
endpackage

// File: rtl/lbp_classify.sv
module lbp_classify
   import lbp_pkg::*;
#(
   parameter int NPAR = 32
) (
   input  logic [NPAR*PARCEL_W-1:0] line_i,
   output logic [NPAR-1:0]          wide_o
);
   for (genvar i = 0; i < NPAR; i++) begin : g_par
      assign wide_o[i] = (line_i[i*PARCEL_W +: CLASS_BITS] == WIDE_CODE);
   end
endmodule

// File: rtl/lbp_scan.sv
module lbp_scan #(
   parameter int NPAR       = 32,
   parameter bit SCAN_SPLIT = 1'b0
) (
   input  logic [NPAR-1:0] wide_i,
   output logic [NPAR-1:0] start_o,
   output logic [NPAR-1:0] len_o,
   output logic            fault_o
);
   localparam int HALF = NPAR / 2;

   if (!SCAN_SPLIT) begin : g_ripple
      always_comb begin
         logic run;
         run = 1'b1;
         for (int i = 0; i < NPAR; i++) begin
            start_o[i] = run;
            run = ~(run & wide_i[i]);
         end
      end
   end else begin : g_split
      logic [HALF-1:0] lo_st, hi_st1, hi_st0;
      logic            lo_out;
      always_comb begin
         logic r;
         r = 1'b1;
         for (int i = 0; i < HALF; i++) begin
            lo_st[i] = r;
            r = ~(r & wide_i[i]);
         end
         lo_out = r;
      end
      always_comb begin
         logic r1, r0;
         r1 = 1'b1;
         r0 = 1'b0;
         for (int i = 0; i < HALF; i++) begin
            hi_st1[i] = r1;
            hi_st0[i] = r0;
            r1 = ~(r1 & wide_i[HALF+i]);
            r0 = ~(r0 & wide_i[HALF+i]);
         end
      end
      assign start_o = {(lo_out ? hi_st1 : hi_st0), lo_st};
   end

   assign len_o   = start_o & wide_i;
   assign fault_o = len_o[NPAR-1];
endmodule

// File: rtl/lbp_target.sv
module lbp_target #(
   parameter int NPAR = 32,
   localparam int IW = $clog2(NPAR)
) (
   input  logic [IW-1:0]   idx_i,
   input  logic [NPAR-1:0] mask_i,
   output logic            misaligned_o
);
   assign misaligned_o = ~mask_i[idx_i];
endmodule

// File: rtl/lbp_predecoder.sv
module lbp_predecoder
   import lbp_pkg::*;
#(
   parameter int LINE_BYTES = 64,
   parameter bit SCAN_SPLIT = 1'b0,
   localparam int NPAR = LINE_BYTES * 8 / PARCEL_W,
   localparam int IW   = $clog2(NPAR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill_valid_i,
   input  logic [LINE_BYTES*8-1:0]  fill_line_i,
   output logic [NPAR-1:0]          start_mask_o,
   output logic [NPAR-1:0]          len_mask_o,
   output logic                     cross_fault_o,
   input  logic [IW-1:0]            tgt_idx_i,
   input  logic [NPAR-1:0]          tgt_mask_i,
   output logic                     tgt_misaligned_o
);
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end

   logic [NPAR-1:0] wide_w, start_w, len_w;
   logic            fault_w;
   logic [NPAR-1:0] start_q, len_q;
   logic            fault_q;

   lbp_classify #(.NPAR(NPAR)) u_classify (
      .line_i (fill_line_i),
      .wide_o (wide_w)
   );

   lbp_scan #(.NPAR(NPAR), .SCAN_SPLIT(SCAN_SPLIT)) u_scan (
      .wide_i  (wide_w),
      .start_o (start_w),
      .len_o   (len_w),
      .fault_o (fault_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         len_q   <= '0;
         fault_q <= 1'b0;
      end else if (fill_valid_i) begin
         start_q <= start_w;
         len_q   <= len_w;
         fault_q <= fault_w;
      end
   end

   assign start_mask_o  = start_q;
   assign len_mask_o    = len_q;
   assign cross_fault_o = fault_q;

   lbp_target #(.NPAR(NPAR)) u_target (
      .idx_i        (tgt_idx_i),
      .mask_i       (tgt_mask_i),
      .misaligned_o (tgt_misaligned_o)
   );

   logic [NPAR-1:0] cont_w;
   assign cont_w = (start_q & len_q) << 1;

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fill_valid_i) |-> ($stable(start_q) && $stable(len_q) && $stable(fault_q)));
   a_r3_first_start: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fill_valid_i) |-> start_q[0]);
   a_r5_no_start_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_w & start_q) == '0);
   a_r5_full_cover: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fill_valid_i) |-> ((cont_w | start_q) == '1));
   a_r6_len_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q & ~start_q) == '0);
   a_r7_fault_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      cross_fault_o |-> (start_q[NPAR-1] && len_q[NPAR-1]));
endmodule

// File: tb/lbp_predecoder_bench.sv
`timescale 1ns/1ps
module lbp_predecoder_bench;
   localparam int NPAR = 32;
   logic clk = 1'b0, rst_n = 1'b0, fill_valid = 1'b0;
   logic [511:0] line = '0;
   logic [4:0] tidx = '0;
   logic [31:0] tmask = '0;
   logic [31:0] st_a, ln_a, st_b, ln_b;
   logic flt_a, flt_b, mis_a, mis_b;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lbp_predecoder u_lbp_predecoder (
      .clk(clk), .rst_n(rst_n), .fill_valid_i(fill_valid), .fill_line_i(line),
      .start_mask_o(st_a), .len_mask_o(ln_a), .cross_fault_o(flt_a),
      .tgt_idx_i(tidx), .tgt_mask_i(tmask), .tgt_misaligned_o(mis_a));

   lbp_predecoder #(.SCAN_SPLIT(1'b1)) u_lbp_predecoder_split (
      .clk(clk), .rst_n(rst_n), .fill_valid_i(fill_valid), .fill_line_i(line),
      .start_mask_o(st_b), .len_mask_o(ln_b), .cross_fault_o(flt_b),
      .tgt_idx_i(tidx), .tgt_mask_i(tmask), .tgt_misaligned_o(mis_b));

   function automatic logic [64:0] ref_scan(input logic [511:0] l);
      logic [31:0] s, w;
      logic nxt;
      nxt = 1'b1;
      s = '0; w = '0;
      for (int i = 0; i < NPAR; i++) begin
         s[i] = nxt;
         w[i] = nxt && (l[16*i +: 2] == 2'b11);
         nxt = !w[i];
      end
      return {w[31], w, s};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [64:0] cur;

   task automatic do_fill(input logic [511:0] l, input string tag);
      logic [64:0] e;
      e = ref_scan(l);
      line = l;
      fill_valid = 1'b1;
      tmask = st_a;
      tidx = 5'($urandom_range(0, 31));
      #1;
      chk({"R8 lookup before edge ", tag}, {63'd0, mis_a}, {63'd0, !cur[tidx]});
      @(negedge clk);
      fill_valid = 1'b0;
      cur = e;
      chk({"R3/R4/R5 starts ", tag}, {32'd0, st_a}, {32'd0, e[31:0]});
      chk({"R6 len ", tag}, {32'd0, ln_a}, {32'd0, e[63:32]});
      chk({"R7 fault ", tag}, {63'd0, flt_a}, {63'd0, e[64]});
      chk({"R9 split variant ", tag}, {st_b, ln_b}, {st_a, ln_a});
      chk({"R9 split fault ", tag}, {63'd0, flt_b}, {63'd0, flt_a});
      tmask = st_a;
      #1;
      chk({"R8 lookup after edge ", tag}, {63'd0, mis_a}, {63'd0, !e[tidx]});
      chk({"R8 split lookup ", tag}, {63'd0, mis_b}, {63'd0, mis_a});
   endtask

   initial begin
      logic [511:0] l;
      void'($urandom(32'h1234abcd));
      cur = '0;
      #5;
      chk("R1 reset masks", {st_a, ln_a}, 64'd0);
      chk("R1 reset fault", {63'd0, flt_a}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {31'd0, flt_a, st_a}, 64'd0);

      do_fill('0, "all16");
      do_fill({512{1'b1}}, "all32");
      l = {512{1'b1}};
      l[1:0] = 2'b00;
      do_fill(l, "cross");
      chk("R7 crossing line faults", {63'd0, flt_a}, 64'd1);
      l = '0;
      l[1:0] = 2'b11;
      l[17:16] = 2'b11;
      l[33:32] = 2'b01;
      do_fill(l, "R5 ignored second parcel");
      chk("R5 parcel1 not start, parcel2 start", {62'd0, st_a[2:1]}, 64'd2);
      l = '0;
      l[31*16 +: 2] = 2'b11;
      do_fill(l, "last wide");
      chk("R7 last parcel wide start", {61'd0, flt_a, st_a[31], ln_a[31]}, 64'd7);

      l = {512{1'b1}};
      line = ~l;
      repeat (3) @(negedge clk);
      chk("R2 hold without pulse", {31'd0, flt_a, st_a}, {31'd0, cur[64], cur[31:0]});

      for (int n = 0; n < 300; n++) begin
         for (int k = 0; k < 16; k++) l[32*k +: 32] = $urandom();
         if (n % 3 == 0)
            for (int k = 0; k < 32; k++) if ($urandom_range(0, 1) == 1) l[16*k +: 2] = 2'b11;
         do_fill(l, "random");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule